// File: doc/BRIEF.md
# Rename-Dispatch Steering Stage

This stage moves micro-ops from the head of a micro-op queue into the back end. In each cycle it looks at up to `WIDTH` head slots. Slot 0 is the oldest. Before each slot it checks for a stall. Every micro-op that passes the check is written into the reorder buffer and carries its tag unchanged, because renaming here is a plain pass-through. The micro-op is then steered by its memory flag. A memory micro-op goes to the load/store queue, and any other micro-op goes to the issue queue.

The first slot that fails the check ends dispatch for the rest of the cycle. The stage reports why it stopped and how many slots went unused. A bank of saturating counters keeps these statistics:

- Unused slots, charged to the reason that stopped dispatch.
- Used slots, split by the speculative-mode flag into a speculative count and a non-speculative count.
- Reorder-buffer writes.
- Issue-queue writes.
- Load/store-queue writes.

The dispatch decision is combinational, from the slot inputs to the write strobes, in the same cycle. The counters update on the following clock edge.

Top module: `dispatch_steer`

## Requirements
- R1: In each cycle, at most `WIDTH` micro-ops are taken, and only from the head in order. `q_take` is always a contiguous run of ones starting at slot 0.
- R2: Slot i is checked in this fixed priority, and the first condition that holds gives the stall reason code:
  - slot invalid gives 2 (queue empty);
  - i >= `rob_free` gives 3 (ROB full);
  - a non-memory micro-op while the non-memory micro-ops taken earlier this cycle are >= `iq_free` gives 4 (IQ full);
  - a memory micro-op while the memory micro-ops taken earlier this cycle are >= `lsq_free` gives 5 (LSQ full);
  - i >= `ren_free` gives 6 (rename registers unavailable);
  - otherwise the code is 0 (used).
- R3: The first slot whose code is not 0 ends dispatch. `stop_reason` then shows that code and `stop_slots` shows `WIDTH` minus the number of slots taken. When every slot is taken, `stop_reason` is 0 and `stop_slots` is 0.
- R4: Every taken slot raises its `rob_we` bit. Its `rob_tag` field carries the slot's `q_tag` field unchanged.
- R5: A taken slot with `q_mem`=1 raises `lsq_we` and not `iq_we`. A taken slot with `q_mem`=0 raises `iq_we` and not `lsq_we`. Slots that are not taken raise no strobe.
- R6: On the next clock edge, the `stat_cnt` counter whose index equals the stop reason (2 to 6) grows by `stop_slots`.
- R7: On the next clock edge, `stat_cnt` index 1 (speculative) grows by the number of slots taken when `spec_mode`=1. Otherwise `stat_cnt` index 0 (used) grows by that number.
- R8: On the next clock edge, `rob_wr_cnt` grows by the number of slots taken. `iq_wr_cnt` and `lsq_wr_cnt` grow by the number of bits raised in `iq_we` and `lsq_wr` respectively.
- R9: Every counter saturates at 2^`CNT_W`-1 and never wraps or decreases.
- R10: Reset clears every counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the counters |
| q_valid | input | 4 | Per head slot: entry present (slot 0 oldest) |
| q_mem | input | 4 | Per head slot: memory micro-op flag |
| q_tag | input | 32 | Per head slot: 8-bit tag, slot i at bits [8i+7:8i] |
| spec_mode | input | 1 | Micro-ops of this cycle are speculative |
| rob_free | input | 8 | Free reorder-buffer entries |
| iq_free | input | 8 | Free issue-queue entries |
| lsq_free | input | 8 | Free load/store-queue entries |
| ren_free | input | 8 | Free rename registers |
| q_take | output | 4 | Per slot: taken from the queue this cycle |
| rob_we | output | 4 | Per slot: reorder-buffer write strobe |
| rob_tag | output | 32 | Per slot: tag written with the micro-op |
| iq_we | output | 4 | Per slot: issue-queue write strobe |
| lsq_we | output | 4 | Per slot: load/store-queue write strobe |
| stop_reason | output | 3 | Code of the reason that ended dispatch, 0 if none |
| stop_slots | output | 3 | Slots left unused this cycle |
| stat_cnt | output | 224 | Seven counters indexed by reason code, index r at bits [32r+31:32r] |
| rob_wr_cnt | output | 32 | Reorder-buffer write count |
| iq_wr_cnt | output | 32 | Issue-queue write count |
| lsq_wr_cnt | output | 32 | Load/store-queue write count |

## Verification
Random cycles mix the following, and their results are compared with a bench model of the slot checks:

- queue heads with holes;
- random memory flags;
- capacities that are small and often zero, so that every stall reason comes first at some slot.

Directed cycles put two conditions at the same slot, for example:

- empty with ROB full;
- IQ full with no rename registers;
- a memory micro-op facing a full issue queue.

Together these separate the priority order from a plain "any resource short" test. A directed cycle with one IQ entry and two non-memory micro-ops tells a per-type count apart from a count over all slots. A long run of full-width dispatch drives the counters into saturation.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;

  typedef enum logic [2:0] {
    RSN_USED  = 3'd0,
    RSN_SPEC  = 3'd1,
    RSN_EMPTY = 3'd2,
    RSN_ROB   = 3'd3,
    RSN_IQ    = 3'd4,
    RSN_LSQ   = 3'd5,
    RSN_REN   = 3'd6
  } reason_e;

  localparam int NUM_RSN = 7;
  localparam int NUM_CNT = NUM_RSN + 3;

  // Stall check of one slot in priority order; counts are occupancy already
  // claimed by earlier slots of the same cycle.
  function automatic reason_e slot_check(
    input logic valid, input logic mem, input int slot,
    input int iq_before, input int lsq_before,
    input int rob_free, input int iq_free, input int lsq_free, input int ren_free);
    if (!valid)                           return RSN_EMPTY;
    if (slot >= rob_free)                 return RSN_ROB;
    if (!mem && iq_before >= iq_free)     return RSN_IQ;
    if (mem && lsq_before >= lsq_free)    return RSN_LSQ;
    if (slot >= ren_free)                 return RSN_REN;
    return RSN_USED;
  endfunction

endpackage

// File: rtl/ds_slot_select.sv
module ds_slot_select
  import dispatch_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter int FREE_W = 8,
  localparam int CW    = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0]  q_valid,
  input  logic [WIDTH-1:0]  q_mem,
  input  logic [FREE_W-1:0] rob_free,
  input  logic [FREE_W-1:0] iq_free,
  input  logic [FREE_W-1:0] lsq_free,
  input  logic [FREE_W-1:0] ren_free,
  output logic [WIDTH-1:0]  take,
  output logic [WIDTH-1:0]  to_iq,
  output logic [WIDTH-1:0]  to_lsq,
  output logic [CW-1:0]     n_disp,
  output reason_e           stop_rsn
);

  reason_e slot_rsn [WIDTH];

  always_comb begin : chain
    int   iq_b;
    int   lsq_b;
    int   cnt;
    logic go;
    iq_b     = 0;
    lsq_b    = 0;
    cnt      = 0;
    go       = 1'b1;
    take     = '0;
    to_iq    = '0;
    to_lsq   = '0;
    stop_rsn = RSN_USED;
    for (int i = 0; i < WIDTH; i++) begin
      slot_rsn[i] = slot_check(q_valid[i], q_mem[i], i, iq_b, lsq_b,
                               int'(rob_free), int'(iq_free),
                               int'(lsq_free), int'(ren_free));
      if (go) begin
        if (slot_rsn[i] == RSN_USED) begin
          take[i] = 1'b1;
          cnt     = cnt + 1;
          if (q_mem[i]) begin
            to_lsq[i] = 1'b1;
            lsq_b     = lsq_b + 1;
          end else begin
            to_iq[i] = 1'b1;
            iq_b     = iq_b + 1;
          end
        end else begin
          go       = 1'b0;
          stop_rsn = slot_rsn[i];
        end
      end
    end
    n_disp = CW'(cnt);
  end

endmodule

// File: rtl/ds_sat_counter.sv
module ds_sat_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] count
);

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [INC_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + (CNT_W + 1)'(b);
    return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= sat_add(count, inc);
  end

  // R9: a counter never goes backwards (no wrap)
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count >= $past(count));

  // R9: once saturated it stays saturated
  p_hold_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&count) |=> (&count));

endmodule

// File: rtl/dispatch_steer.sv
module dispatch_steer
  import dispatch_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter int TAG_W  = 8,
  parameter int FREE_W = 8,
  parameter int CNT_W  = 32,
  localparam int CW    = $clog2(WIDTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WIDTH-1:0]         q_valid,
  input  logic [WIDTH-1:0]         q_mem,
  input  logic [WIDTH*TAG_W-1:0]   q_tag,
  input  logic                     spec_mode,
  input  logic [FREE_W-1:0]        rob_free,
  input  logic [FREE_W-1:0]        iq_free,
  input  logic [FREE_W-1:0]        lsq_free,
  input  logic [FREE_W-1:0]        ren_free,
  output logic [WIDTH-1:0]         q_take,
  output logic [WIDTH-1:0]         rob_we,
  output logic [WIDTH*TAG_W-1:0]   rob_tag,
  output logic [WIDTH-1:0]         iq_we,
  output logic [WIDTH-1:0]         lsq_we,
  output logic [2:0]               stop_reason,
  output logic [CW-1:0]            stop_slots,
  output logic [NUM_RSN*CNT_W-1:0] stat_cnt,
  output logic [CNT_W-1:0]         rob_wr_cnt,
  output logic [CNT_W-1:0]         iq_wr_cnt,
  output logic [CNT_W-1:0]         lsq_wr_cnt
);

  logic [CW-1:0] n_disp;
  reason_e       stop_rsn;
  logic          stopped;
  logic [CW-1:0] inc_v [NUM_CNT];
  logic [CNT_W-1:0] cnt_v [NUM_CNT];

  ds_slot_select #(.WIDTH(WIDTH), .FREE_W(FREE_W)) u_sel (
    .q_valid  (q_valid),
    .q_mem    (q_mem),
    .rob_free (rob_free),
    .iq_free  (iq_free),
    .lsq_free (lsq_free),
    .ren_free (ren_free),
    .take     (q_take),
    .to_iq    (iq_we),
    .to_lsq   (lsq_we),
    .n_disp   (n_disp),
    .stop_rsn (stop_rsn)
  );

  assign rob_we      = q_take;
  assign stopped     = (stop_rsn != RSN_USED);
  assign stop_reason = stop_rsn;
  assign stop_slots  = stopped ? (CW'(WIDTH) - n_disp) : '0;

  for (genvar s = 0; s < WIDTH; s++) begin : g_tag
    assign rob_tag[s*TAG_W +: TAG_W] = q_take[s] ? q_tag[s*TAG_W +: TAG_W] : '0;
  end

  always_comb begin
    inc_v[RSN_USED] = spec_mode ? '0 : n_disp;
    inc_v[RSN_SPEC] = spec_mode ? n_disp : '0;
    for (int r = 2; r < NUM_RSN; r++)
      inc_v[r] = (stopped && stop_rsn == reason_e'(r)) ? stop_slots : '0;
    inc_v[NUM_RSN]     = n_disp;
    inc_v[NUM_RSN + 1] = CW'($countones(iq_we));
    inc_v[NUM_RSN + 2] = CW'($countones(lsq_we));
  end

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    ds_sat_counter #(.CNT_W(CNT_W), .INC_W(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc_v[c]),
      .count (cnt_v[c])
    );
  end

  for (genvar r = 0; r < NUM_RSN; r++) begin : g_stat
    assign stat_cnt[r*CNT_W +: CNT_W] = cnt_v[r];
  end
  assign rob_wr_cnt = cnt_v[NUM_RSN];
  assign iq_wr_cnt  = cnt_v[NUM_RSN + 1];
  assign lsq_wr_cnt = cnt_v[NUM_RSN + 2];

  // R1: taken slots form a prefix starting at the oldest entry
  p_prefix_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_take + WIDTH'(1)) & q_take) == '0);

  // R1: nothing taken from an empty slot
  p_valid_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (q_take & ~q_valid) == '0);

  // R2: capacity of the downstream buffers is never exceeded
  p_capacity_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rob_we) <= int'(rob_free) && $countones(iq_we) <= int'(iq_free) &&
    $countones(lsq_we) <= int'(lsq_free) && $countones(q_take) <= int'(ren_free));

  // R3: full dispatch reports no stall
  p_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_reason == 3'd0) |-> (&q_take) && stop_slots == '0);

  // R5: every taken slot goes to exactly one of the two queues
  p_steer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_we & lsq_we) == '0 && (iq_we | lsq_we) == rob_we);

  // R7: speculative counter stays still while not speculative
  p_spec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !spec_mode |=> $stable(cnt_v[RSN_SPEC]));

endmodule

// File: tb/dispatch_steer_tb.sv
module dispatch_steer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W     = 4;
  localparam int TAG_W = 8;
  localparam int FW    = 8;
  localparam int CNT_W = 10;
  localparam int CW    = 3;
  localparam int NCNT  = 10;
  localparam longint CMAX = (64'd1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] q_valid = '0, q_mem = '0;
  logic [W*TAG_W-1:0] q_tag = '0;
  logic spec_mode = 1'b0;
  logic [FW-1:0] rob_free = '0, iq_free = '0, lsq_free = '0, ren_free = '0;
  logic [W-1:0] q_take, rob_we, iq_we, lsq_we;
  logic [W*TAG_W-1:0] rob_tag;
  logic [2:0] stop_reason;
  logic [CW-1:0] stop_slots;
  logic [7*CNT_W-1:0] stat_cnt;
  logic [CNT_W-1:0] rob_wr_cnt, iq_wr_cnt, lsq_wr_cnt;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  longint exp_cnt [NCNT];

  always #(CLK_PERIOD/2) clk = ~clk;

  dispatch_steer #(.WIDTH(W), .TAG_W(TAG_W), .FREE_W(FW), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_mem(q_mem), .q_tag(q_tag),
    .spec_mode(spec_mode), .rob_free(rob_free), .iq_free(iq_free),
    .lsq_free(lsq_free), .ren_free(ren_free), .q_take(q_take), .rob_we(rob_we),
    .rob_tag(rob_tag), .iq_we(iq_we), .lsq_we(lsq_we), .stop_reason(stop_reason),
    .stop_slots(stop_slots), .stat_cnt(stat_cnt), .rob_wr_cnt(rob_wr_cnt),
    .iq_wr_cnt(iq_wr_cnt), .lsq_wr_cnt(lsq_wr_cnt));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint cnt_out(input int idx);
    if (idx < 7) return longint'(stat_cnt[idx*CNT_W +: CNT_W]);
    if (idx == 7) return longint'(rob_wr_cnt);
    if (idx == 8) return longint'(iq_wr_cnt);
    return longint'(lsq_wr_cnt);
  endfunction

  // Bench restatement of the per-slot check order.
  function automatic int slot_code(input logic v, input logic m, input int i,
                                   input int nonmem_prev, input int mem_prev,
                                   input int rf, input int iqf, input int lsf, input int rnf);
    int code;
    code = 0;
    if (rnf <= i) code = 6;
    if (m && lsf <= mem_prev) code = 5;
    if (!m && iqf <= nonmem_prev) code = 4;
    if (rf <= i) code = 3;
    if (!v) code = 2;
    return code;
  endfunction

  task automatic cycle(input logic [W-1:0] v, input logic [W-1:0] m, input logic sp,
                       input int rf, input int iqf, input int lsf, input int rnf,
                       input logic [W*TAG_W-1:0] tg);
    logic [W-1:0] e_take, e_iq, e_lsq;
    logic [W*TAG_W-1:0] e_tag;
    int e_rsn, e_n, nm, mm;
    bit halted;
    q_valid = v; q_mem = m; spec_mode = sp; q_tag = tg;
    rob_free = FW'(rf); iq_free = FW'(iqf); lsq_free = FW'(lsf); ren_free = FW'(rnf);
    e_take = '0; e_iq = '0; e_lsq = '0; e_tag = '0;
    e_rsn = 0; e_n = 0; nm = 0; mm = 0; halted = 0;
    for (int i = 0; i < W; i++) begin
      if (!halted) begin
        int c;
        c = slot_code(v[i], m[i], i, nm, mm, rf, iqf, lsf, rnf);
        if (c != 0) begin
          halted = 1; e_rsn = c;
        end else begin
          e_take[i] = 1'b1; e_n++;
          e_tag[i*TAG_W +: TAG_W] = tg[i*TAG_W +: TAG_W];
          if (m[i]) begin e_lsq[i] = 1'b1; mm++; end
          else begin e_iq[i] = 1'b1; nm++; end
        end
      end
    end
    #4;
    chk("R1", "q_take", q_take, e_take);
    chk("R2", "stop_reason", stop_reason, e_rsn);
    chk("R3", "stop_slots", stop_slots, halted ? (W - e_n) : 0);
    chk("R4", "rob_we", rob_we, e_take);
    chk("R4", "rob_tag", rob_tag, e_tag);
    chk("R5", "iq_we", iq_we, e_iq);
    chk("R5", "lsq_we", lsq_we, e_lsq);
    @(posedge clk); #1;
    if (sp) exp_cnt[1] += e_n; else exp_cnt[0] += e_n;
    if (halted) exp_cnt[e_rsn] += W - e_n;
    exp_cnt[7] += e_n; exp_cnt[8] += nm; exp_cnt[9] += mm;
    for (int k = 0; k < NCNT; k++) if (exp_cnt[k] > CMAX) exp_cnt[k] = CMAX;
    for (int k = 0; k < 2; k++) chk("R7", $sformatf("stat_cnt[%0d]", k), cnt_out(k), exp_cnt[k]);
    for (int k = 2; k < 7; k++) chk("R6", $sformatf("stat_cnt[%0d]", k), cnt_out(k), exp_cnt[k]);
    chk("R8", "rob_wr_cnt", cnt_out(7), exp_cnt[7]);
    chk("R8", "iq_wr_cnt", cnt_out(8), exp_cnt[8]);
    chk("R8", "lsq_wr_cnt", cnt_out(9), exp_cnt[9]);
  endtask

  function automatic int small_free();
    int r;
    r = int'($urandom_range(0, 9));
    return (r < 7) ? r % 4 : 4 + r;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < NCNT; k++) exp_cnt[k] = 0;
    repeat (3) @(posedge clk);
    #1;
    for (int k = 0; k < NCNT; k++) chk("R10", $sformatf("counter %0d at reset", k), cnt_out(k), 0);
    rst_n = 1'b1;

    // Directed corner cases
    cycle(4'b0000, 4'b0000, 0, 8, 8, 8, 8, 32'h0);            // R2 empty queue
    cycle(4'b1111, 4'b0000, 0, 0, 8, 8, 8, 32'h0);            // R2 ROB full at slot 0
    cycle(4'b0000, 4'b0000, 0, 0, 0, 0, 0, 32'h0);            // R2 empty beats ROB full
    cycle(4'b1111, 4'b0000, 0, 8, 1, 8, 8, 32'h44332211);     // R2 IQ full at slot 1
    cycle(4'b1111, 4'b0101, 1, 8, 1, 8, 8, 32'hA4A3A2A1);     // R5 mem skips IQ limit
    cycle(4'b1111, 4'b1111, 1, 8, 0, 0, 8, 32'h0);            // R2 LSQ full, IQ ignored
    cycle(4'b1111, 4'b0000, 0, 8, 0, 8, 0, 32'h0);            // R2 IQ beats rename
    cycle(4'b1111, 4'b1010, 0, 2, 8, 8, 1, 32'h0);            // R2 rename at slot 1
    cycle(4'b1111, 4'b1001, 1, 4, 4, 4, 4, 32'hDEADBEEF);     // R3 full dispatch
    cycle(4'b1011, 4'b0000, 0, 8, 8, 8, 8, 32'h0);            // R1 hole at slot 2

    // Constrained random
    for (int t = 0; t < 400; t++) begin
      logic [W-1:0] v;
      v = W'($urandom);
      if ($urandom_range(0, 1) == 1) v = W'((1 << $urandom_range(0, W)) - 1);
      cycle(v, W'($urandom), 1'($urandom), small_free(), small_free(),
            small_free(), small_free(), $urandom);
    end

    // R9 saturation: long full-width non-speculative run
    for (int t = 0; t < 280; t++)
      cycle(4'b1111, 4'b0011, 0, 9, 9, 9, 9, $urandom);
    chk("R9", "used counter saturated", cnt_out(0), CMAX);
    chk("R9", "rob_wr_cnt saturated", cnt_out(7), CMAX);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule